// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block holds characters that a serial receiver has assembled until software collects them. It stores up to 64 characters. Each one carries three flags raised by the receiver: a break condition, a stop-bit (framing) fault and a parity mismatch. The receiver writes into the queue through a single-cycle push port. Software reads through two strobes. The status strobe returns a status byte and leaves the queue unchanged. The holding strobe returns the oldest character and removes it.

The break, framing and parity bits in the status byte have no storage of their own. They are routed combinationally from the entry at the head of the queue, so they always describe the next character that a holding read will return. A separate summary flag stays set while any stored character still carries an error. That flag is also raised by a holding read made while the queue is empty. After such an underrun the flag can only be cleared by a software clear of the queue. The clear empties the queue in a single cycle.

Top module: `rxq_err_fifo`

## Requirements
- R1: After synchronous reset the queue is empty, and `data_ready`, `any_err` and `overrun` are all 0.
- R2: Characters leave in the order they were pushed. While `rd_rhr` is high and the queue is non-empty, `rd_data` shows the head character in the same cycle, and that entry is removed at the next clock edge. A pushed character becomes visible from the cycle after the push.
- R3: While `rd_lsr` is high and `rd_rhr` is low, `rd_data` is the status byte. Its layout is: bit 0 = data ready, bit 2 = parity flag of the head, bit 3 = framing flag of the head, bit 4 = break flag of the head, bit 7 = summary error. Bits 1, 5 and 6 read 0. A status read never removes an entry.
- R4: `any_err` (status bit 7) is 1 while at least one stored entry has any of its three flags set. It returns to 0 in the cycle after the last such entry is popped.
- R5: The queue holds exactly 64 entries. A push into a full queue without a pop in the same cycle is discarded. In that case `overrun` is 1 for exactly the following cycle.
- R6: A push and a pop in the same cycle are both performed, including when the queue is full. The occupancy then stays the same and no overrun is reported.
- R7: A holding read while the queue is empty moves no pointer. It sets `any_err` from the next cycle, and `any_err` then stays set regardless of later pushes and pops until `fifo_clear`.
- R8: `fifo_clear` empties the queue and zeroes the error state in one cycle. It takes priority over a push or pop in the same cycle, and the cleared state is visible the cycle after.
- R9: With neither strobe high, `rd_data` is 0. When both strobes are high, the holding read takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_brk | input | 1 | Break detected for this character |
| push_frm | input | 1 | Framing fault for this character |
| push_par | input | 1 | Parity fault for this character |
| rd_lsr | input | 1 | Status register read strobe |
| rd_rhr | input | 1 | Holding register read strobe (pops) |
| fifo_clear | input | 1 | Software clear of the queue |
| rd_data | output | 8 | Read data bus |
| data_ready | output | 1 | Queue not empty |
| any_err | output | 1 | Some stored entry has an error, or an underrun occurred |
| overrun | output | 1 | One-cycle pulse after a discarded push |

## Verification
`rd_data` is combinational on the strobes and the current head. The bench drives each stimulus at the falling edge and compares the bus one time unit later, against a queue model that still holds its pre-edge state. `data_ready`, `any_err` and `overrun` change on the rising edge that takes the stimulus. The model therefore applies each stimulus at that rising edge, and these outputs are compared at the next falling-edge sample, one cycle after the stimulus. Head-flag bits and holding data are left unchecked while the model queue is empty, because the head entry is stale then.

// File: rtl/rxq_err_pkg.sv
package rxq_err_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] chr;
    } rxq_entry_t;

    typedef struct packed {
        logic pop;       // entry leaves the head
        logic push;      // entry is written at the tail
        logic underrun;  // holding read on an empty queue
        logic drop;      // push discarded because the queue is full
    } rxq_ops_t;

    function automatic logic entry_bad(rxq_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

    function automatic logic [7:0] status_byte(logic err, rxq_entry_t head, logic ready);
        return {err, 2'b00, head.brk, head.frm, head.par, 1'b0, ready};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_err_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  rxq_entry_t       wr_entry,
    input  logic             rd_en,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] occ
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_err_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             push_valid,
    input  logic             rd_rhr,
    input  logic             clr,
    input  logic [CNT_W-1:0] occ,
    output rxq_ops_t         ops
);
    logic empty, full;

    always_comb begin
        empty        = (occ == '0);
        full         = (occ == CNT_W'(DEPTH));
        ops.pop      = rd_rhr && !empty && !clr;
        ops.underrun = rd_rhr && empty && !clr;
        ops.push     = push_valid && !clr && (!full || ops.pop);
        ops.drop     = push_valid && !clr && full && !ops.pop;
    end
endmodule

// File: rtl/rxq_err_tally.sv
module rxq_err_tally #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    input  logic             underrun,
    output logic [CNT_W-1:0] err_cnt,
    output logic             corrupt,
    output logic             any_err
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_cnt <= '0;
            corrupt <= 1'b0;
        end else begin
            if (inc && !dec)      err_cnt <= err_cnt + 1'b1;
            else if (dec && !inc) err_cnt <= err_cnt - 1'b1;
            if (underrun)         corrupt <= 1'b1;
        end
    end

    assign any_err = (err_cnt != '0) || corrupt;
endmodule

// File: rtl/rxq_rdmux.sv
module rxq_rdmux
    import rxq_err_pkg::*;
(
    input  logic       rd_lsr,
    input  logic       rd_rhr,
    input  rxq_entry_t head,
    input  logic       ready,
    input  logic       err,
    output logic [7:0] rd_data
);
    always_comb begin
        if (rd_rhr)      rd_data = head.chr;
        else if (rd_lsr) rd_data = status_byte(err, head, ready);
        else             rd_data = '0;
    end
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
    import rxq_err_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       push_brk,
    input  logic       push_frm,
    input  logic       push_par,
    input  logic       rd_lsr,
    input  logic       rd_rhr,
    input  logic       fifo_clear,
    output logic [7:0] rd_data,
    output logic       data_ready,
    output logic       any_err,
    output logic       overrun
);
    rxq_entry_t       in_entry, head;
    rxq_ops_t         ops;
    logic [CNT_W-1:0] occ, err_cnt;
    logic             corrupt;

    assign in_entry = '{brk: push_brk, frm: push_frm, par: push_par, chr: push_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .push_valid(push_valid), .rd_rhr(rd_rhr), .clr(fifo_clear),
        .occ(occ), .ops(ops)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(fifo_clear),
        .wr_en(ops.push), .wr_entry(in_entry),
        .rd_en(ops.pop), .head(head), .occ(occ)
    );

    rxq_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk(clk), .rst(rst), .clr(fifo_clear),
        .inc(ops.push && entry_bad(in_entry)),
        .dec(ops.pop && entry_bad(head)),
        .underrun(ops.underrun),
        .err_cnt(err_cnt), .corrupt(corrupt), .any_err(any_err)
    );

    assign data_ready = (occ != '0);

    rxq_rdmux u_mux (
        .rd_lsr(rd_lsr), .rd_rhr(rd_rhr), .head(head),
        .ready(data_ready), .err(any_err), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst || fifo_clear) overrun <= 1'b0;
        else                   overrun <= ops.drop;
    end
endmodule

// File: rtl/rxq_err_fifo_chk.sv
module rxq_err_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic             rd_lsr,
    input logic             rd_rhr,
    input logic             fifo_clear,
    input logic             data_ready,
    input logic             any_err,
    input logic             overrun,
    input logic [CNT_W-1:0] occ,
    input logic [CNT_W-1:0] err_cnt
);
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> (!data_ready && !any_err && !overrun));

    assert_status_read_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !rd_rhr && !push_valid && !fifo_clear) |=> $stable(occ));

    assert_drop_only_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (occ == CNT_W'(DEPTH)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_errs_within_queue_R4: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= occ);

    assert_underrun_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_rhr && !data_ready && !fifo_clear) |=> any_err);
endmodule

bind rxq_err_fifo rxq_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .rd_lsr(rd_lsr),
    .rd_rhr(rd_rhr), .fifo_clear(fifo_clear), .data_ready(data_ready),
    .any_err(any_err), .overrun(overrun), .occ(occ), .err_cnt(err_cnt)
);

// File: tb/sim_rxq_err_fifo.sv
module sim_rxq_err_fifo;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       push_valid, push_brk, push_frm, push_par;
    logic [7:0] push_data;
    logic       rd_lsr, rd_rhr, fifo_clear;
    logic [7:0] rd_data;
    logic       data_ready, any_err, overrun;

    always #4 clk = ~clk;   // 125 MHz

    rxq_err_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
        .rd_lsr(rd_lsr), .rd_rhr(rd_rhr), .fifo_clear(fifo_clear),
        .rd_data(rd_data), .data_ready(data_ready), .any_err(any_err),
        .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: entries packed as {brk, frm, par, data}
    logic [10:0] q[$];
    bit          m_corrupt = 0;
    bit          m_ovr     = 0;

    function automatic int err_entries();
        int n = 0;
        foreach (q[i]) if (q[i][10:8] != 3'b000) n++;
        return n;
    endfunction

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h (mask %02h)", tag, what, act & mask, exp & mask, mask);
        end
    endtask

    task automatic step(string tag, bit pv, logic [10:0] ent, bit lsr, bit rhr, bit clr);
        bit exp_ae, exp_dr;
        @(negedge clk);
        push_valid = pv; {push_brk, push_frm, push_par, push_data} = ent;
        rd_lsr = lsr; rd_rhr = rhr; fifo_clear = clr;
        #1;
        exp_dr = (q.size() > 0);
        exp_ae = (err_entries() > 0) || m_corrupt;
        cmp(tag, "data_ready", {7'd0, data_ready}, {7'd0, exp_dr}, 8'h01);
        cmp(tag, "any_err",    {7'd0, any_err},    {7'd0, exp_ae}, 8'h01);
        cmp(tag, "overrun",    {7'd0, overrun},    {7'd0, m_ovr},  8'h01);
        if (rhr) begin
            if (q.size() > 0) cmp(tag, "rhr data", rd_data, q[0][7:0], 8'hFF);
        end else if (lsr) begin
            cmp(tag, "status", rd_data,
                {exp_ae, 2'b00, (q.size() > 0) ? q[0][10:8] : 3'b000, 1'b0, exp_dr},
                (q.size() > 0) ? 8'hFF : 8'hE3);
        end else begin
            cmp(tag, "idle bus", rd_data, 8'h00, 8'hFF);
        end
        @(posedge clk);
        if (clr) begin
            q.delete(); m_corrupt = 0; m_ovr = 0;
        end else begin
            bit pop, full;
            pop  = rhr && (q.size() > 0);
            full = (q.size() == DEPTH);
            m_ovr = pv && full && !pop;
            if (rhr && q.size() == 0) m_corrupt = 1;
            if (pop) void'(q.pop_front());
            if (pv && (!full || pop)) q.push_back(ent);
        end
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 11'h0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr = 16'hACE1;
        rst = 1'b1; push_valid = 0; push_data = 0; push_brk = 0; push_frm = 0;
        push_par = 0; rd_lsr = 0; rd_rhr = 0; fifo_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        cmp("R1", "reset data_ready", {7'd0, data_ready}, 8'h00, 8'h01);
        cmp("R1", "reset any_err",    {7'd0, any_err},    8'h00, 8'h01);
        cmp("R1", "reset overrun",    {7'd0, overrun},    8'h00, 8'h01);
        cmp("R9", "reset idle bus",   rd_data,            8'h00, 8'hFF);

        // R2: ordering, status reads between pops
        for (int i = 0; i < 5; i++) step("R2", 1, {3'b000, 8'(8'h30 + i)}, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step("R3", 0, 11'h0, 1, 0, 0);
            step("R3", 0, 11'h0, 1, 0, 0);
            step("R2", 0, 11'h0, 0, 1, 0);
        end
        idle("R9", 2);

        // R3/R4: head flags per character, summary flag clears after last bad entry
        step("R4", 1, {3'b100, 8'hA1}, 0, 0, 0);
        step("R4", 1, {3'b000, 8'hA2}, 0, 0, 0);
        step("R4", 1, {3'b010, 8'hA3}, 0, 0, 0);
        step("R4", 1, {3'b001, 8'hA4}, 0, 0, 0);
        step("R4", 1, {3'b000, 8'hA5}, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step("R3", 0, 11'h0, 1, 0, 0);
            step("R4", 0, 11'h0, 0, 1, 0);
        end
        step("R4", 0, 11'h0, 1, 0, 0);

        // R5: fill to 64, then discard
        for (int i = 0; i < DEPTH; i++)
            step("R5", 1, {(i % 9 == 0) ? 3'b010 : 3'b000, 8'(i)}, 0, 0, 0);
        step("R5", 1, {3'b111, 8'hEE}, 0, 0, 0);
        step("R5", 0, 11'h0, 1, 0, 0);
        step("R5", 0, 11'h0, 1, 0, 0);

        // R6: full, push and pop together
        for (int i = 0; i < 4; i++) step("R6", 1, {3'b001, 8'(8'hC0 + i)}, 0, 1, 0);
        step("R6", 0, 11'h0, 1, 0, 0);

        // R9: both strobes, holding wins
        step("R9", 0, 11'h0, 1, 1, 0);

        // R8: clear beats a simultaneous push and pop
        step("R8", 1, {3'b100, 8'h55}, 0, 1, 1);
        step("R8", 0, 11'h0, 1, 0, 0);
        idle("R8", 1);

        // R7: underrun, sticky until clear
        step("R7", 0, 11'h0, 0, 1, 0);
        step("R7", 0, 11'h0, 1, 0, 0);
        step("R7", 1, {3'b000, 8'h11}, 0, 0, 0);
        step("R7", 0, 11'h0, 0, 1, 0);
        step("R7", 0, 11'h0, 1, 0, 0);
        step("R7", 0, 11'h0, 0, 0, 1);
        step("R7", 0, 11'h0, 1, 0, 0);

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R2", lfsr[0] | lfsr[1], {(lfsr[4:2] == 3'b111) ? lfsr[7:5] : 3'b000, lfsr[15:8]},
                 lfsr[3], lfsr[6] & lfsr[9] & (q.size() > 0), (lfsr[15:11] == 5'h1F));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule